// File: doc/BRIEF.md
# Polling Transmit-Mode Sequencer for a USB 3.0 PIPE MAC

This block drives the transmit-side control pins that a USB 3.0 MAC presents to its PHY over the PIPE interface. It covers link training from the LFPS polling substate through the equalisation and training-set phases, up to the point where the link reports U0. The PHY stays in power state P0 for the whole sequence. While polling with LFPS, the transmitter is held in electrical idle. LFPS bursts are made by alternating the receiver-detect/loopback control between a gap level and a burst level, with each length set by a parameter in clock cycles.

When the LFPS exit condition is seen, the block switches the PHY into transmit mode in the next cycle. It does this by releasing electrical idle and clearing the detect/loopback control. It does not wait for any PHY status acknowledgement. It then reports the training pattern phase on a 2-bit selector for a separate pattern generator. The phases run in this order: TSEQ for a fixed number of ordered sets, then TS1 until the receiver reports good training sets, then TS2 for a fixed number of ordered sets. The block then signals U0 and holds there until reset. The pattern generator supplies a one-cycle pulse for every ordered set it completes.

Top module: `pipe_poll_tx_ctrl`

## Requirements
- R1: `power_down` is always 2'b00 (P0) in every state.
- R2: A synchronous reset (`rst` high at a clock edge) returns the block to LFPS polling: `tx_elec_idle`=1, `tx_detrx_lpbk`=0, `pattern_sel`=0, `u0_reached`=0.
- R3: During LFPS polling `tx_elec_idle` is 1, and `tx_detrx_lpbk` repeats a pattern that starts after reset: it is 0 for GAP_CYC cycles, then 1 for BURST_CYC cycles. In the t-th cycle after reset it is 1 exactly when (t mod (GAP_CYC+BURST_CYC)) >= GAP_CYC.
- R4: If `lfps_exit` is high at a single clock edge during LFPS polling, then in the very next cycle `tx_elec_idle`=0, `tx_detrx_lpbk`=0 and `pattern_sel`=1 (TSEQ). No PHY acknowledgement is awaited.
- R5: TSEQ lasts for TSEQ_SETS `os_tick` pulses. After the edge that samples the last of them, `pattern_sel` becomes 2 (TS1).
- R6: TS1 holds until `rx_ts_ok` is sampled high at an edge. `pattern_sel` becomes 3 (TS2) in the next cycle.
- R7: TS2 lasts for TS2_SETS `os_tick` pulses. After the last one, `u0_reached`=1, `pattern_sel`=0 and `tx_elec_idle`=0.
- R8: Once reached, U0 holds until reset. `lfps_exit`, `rx_ts_ok` and `os_tick` have no effect on any output while in U0.
- R9: `tx_detrx_lpbk` is never 1 while `tx_elec_idle` is 0. `os_tick` pulses during TS1 are not counted, so TS2 still lasts a full TS2_SETS pulses. `lfps_exit` during TS1 has no effect on the outputs.
- R10: `pattern_sel` uses this encoding: 0 = idle (LFPS polling or U0), 1 = TSEQ, 2 = TS1, 3 = TS2. The only phase order is 0 to 1 to 2 to 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lfps_exit | input | 1 | LFPS exit condition met (sampled in LFPS polling) |
| rx_ts_ok | input | 1 | Receiver reports good training sets (ends TS1) |
| os_tick | input | 1 | One pulse per ordered set sent by the pattern generator |
| power_down | output | 2 | PIPE power state, fixed at P0 (2'b00) |
| tx_elec_idle | output | 1 | Transmitter electrical idle control |
| tx_detrx_lpbk | output | 1 | Receiver-detect/loopback control, toggled for LFPS |
| pattern_sel | output | 2 | Training pattern phase for the pattern generator |
| u0_reached | output | 1 | Training complete, link in U0 |

## Verification
A corrupted phase state shows up on `pattern_sel` and `tx_elec_idle` in the cycle right after the faulty transition, because both are decoded directly from the state register. A wrong LFPS timer shows up as a shifted edge on `tx_detrx_lpbk` within one burst/gap period. A miscounting ordered-set counter moves the TS1 or U0 transition by one or more `os_tick` pulses. The bench therefore varies when exit occurs across every LFPS position, spaces the ticks irregularly, and adds stray ticks during TS1. It then compares every cycle with positions it computes arithmetically.

// File: rtl/pipe_poll_pkg.sv
package pipe_poll_pkg;

  typedef enum logic [2:0] {
    PS_LFPS = 3'd0,
    PS_TSEQ = 3'd1,
    PS_TS1  = 3'd2,
    PS_TS2  = 3'd3,
    PS_U0   = 3'd4
  } poll_state_e;

  localparam logic [1:0] PAT_IDLE = 2'd0;
  localparam logic [1:0] PAT_TSEQ = 2'd1;
  localparam logic [1:0] PAT_TS1  = 2'd2;
  localparam logic [1:0] PAT_TS2  = 2'd3;

  localparam logic [1:0] PD_P0 = 2'b00;

  // Pattern selector presented for each training state.
  function automatic logic [1:0] pattern_of(input poll_state_e s);
    case (s)
      PS_TSEQ: return PAT_TSEQ;
      PS_TS1:  return PAT_TS1;
      PS_TS2:  return PAT_TS2;
      default: return PAT_IDLE;
    endcase
  endfunction

  // Burst level expected t cycles after reset during LFPS polling.
  function automatic logic lfps_level_at(input int unsigned t,
                                         input int unsigned gap,
                                         input int unsigned burst);
    return (t % (gap + burst)) >= gap;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lfps_toggler.sv
module lfps_toggler #(
  parameter int unsigned BURST_CYC = 16,
  parameter int unsigned GAP_CYC   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic burst
);
  import pipe_poll_pkg::*;

  localparam int unsigned LEN_W = $clog2(max2(BURST_CYC, GAP_CYC) + 1);
  localparam logic [LEN_W-1:0] BURST_LAST = LEN_W'(BURST_CYC - 1);
  localparam logic [LEN_W-1:0] GAP_LAST   = LEN_W'(GAP_CYC - 1);

  logic [LEN_W-1:0] seg_cnt;
  logic             burst_q;
  logic             seg_end;

  assign seg_end = (seg_cnt == (burst_q ? BURST_LAST : GAP_LAST));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      seg_cnt <= '0;
      burst_q <= 1'b0;
    end else if (seg_end) begin
      seg_cnt <= '0;
      burst_q <= !burst_q;
    end else begin
      seg_cnt <= seg_cnt + 1'b1;
    end
  end

  assign burst = burst_q;

endmodule

// File: rtl/os_counter.sv
module os_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  assign last = en && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en && tick) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/poll_seq_fsm.sv
module poll_seq_fsm (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       lfps_exit,
  input  logic                       rx_ts_ok,
  input  logic                       tseq_done,
  input  logic                       ts2_done,
  output pipe_poll_pkg::poll_state_e state
);
  import pipe_poll_pkg::*;

  poll_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PS_LFPS: if (lfps_exit) state_d = PS_TSEQ;
      PS_TSEQ: if (tseq_done) state_d = PS_TS1;
      PS_TS1:  if (rx_ts_ok)  state_d = PS_TS2;
      PS_TS2:  if (ts2_done)  state_d = PS_U0;
      PS_U0:   state_d = PS_U0;
      default: state_d = PS_LFPS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PS_LFPS;
    else     state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/pipe_poll_tx_ctrl.sv
module pipe_poll_tx_ctrl #(
  parameter int unsigned BURST_CYC = 16,
  parameter int unsigned GAP_CYC   = 16,
  parameter int unsigned TSEQ_SETS = 64,
  parameter int unsigned TS2_SETS  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lfps_exit,
  input  logic       rx_ts_ok,
  input  logic       os_tick,
  output logic [1:0] power_down,
  output logic       tx_elec_idle,
  output logic       tx_detrx_lpbk,
  output logic [1:0] pattern_sel,
  output logic       u0_reached
);
  import pipe_poll_pkg::*;

  localparam int unsigned CNT_W = $clog2(max2(TSEQ_SETS, TS2_SETS) + 1);

  poll_state_e      state;
  logic             in_lfps;
  logic             lfps_burst;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_limit;
  logic             set_last;

  // Named events for the checker.
  logic enter_tx;
  logic tseq_done;
  logic ts2_done;

  assign in_lfps   = (state == PS_LFPS);
  assign cnt_en    = (state == PS_TSEQ) || (state == PS_TS2);
  assign cnt_limit = (state == PS_TSEQ) ? CNT_W'(TSEQ_SETS) : CNT_W'(TS2_SETS);
  assign enter_tx  = in_lfps && lfps_exit;
  assign tseq_done = (state == PS_TSEQ) && set_last;
  assign ts2_done  = (state == PS_TS2) && set_last;

  lfps_toggler #(
    .BURST_CYC(BURST_CYC),
    .GAP_CYC  (GAP_CYC)
  ) lfps_i (
    .clk  (clk),
    .rst  (rst),
    .run  (in_lfps),
    .burst(lfps_burst)
  );

  os_counter #(
    .CNT_W(CNT_W)
  ) sets_i (
    .clk  (clk),
    .rst  (rst),
    .en   (cnt_en),
    .tick (os_tick),
    .limit(cnt_limit),
    .last (set_last)
  );

  poll_seq_fsm fsm_i (
    .clk      (clk),
    .rst      (rst),
    .lfps_exit(lfps_exit),
    .rx_ts_ok (rx_ts_ok),
    .tseq_done(tseq_done),
    .ts2_done (ts2_done),
    .state    (state)
  );

  assign power_down    = PD_P0;
  assign tx_elec_idle  = in_lfps;
  assign tx_detrx_lpbk = in_lfps && lfps_burst;
  assign pattern_sel   = pattern_of(state);
  assign u0_reached    = (state == PS_U0);

endmodule

// File: rtl/pipe_poll_tx_ctrl_chk.sv
module pipe_poll_tx_ctrl_chk #(
  parameter int unsigned BURST_CYC = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       lfps_exit,
  input logic       rx_ts_ok,
  input logic [1:0] power_down,
  input logic       tx_elec_idle,
  input logic       tx_detrx_lpbk,
  input logic [1:0] pattern_sel,
  input logic       u0_reached,
  input logic       enter_tx
);
  logic        seen = 1'b0;
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                run_len <= '0;
    else if (tx_detrx_lpbk) run_len <= run_len + 1;
    else                    run_len <= '0;
  end

  AST_POWER_P0: assert property (@(posedge clk) disable iff (rst) seen |-> power_down == 2'b00); // R1
  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> tx_elec_idle && !tx_detrx_lpbk && pattern_sel == 2'd0 && !u0_reached); // R2
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst) (seen && $fell(tx_detrx_lpbk) && tx_elec_idle) |-> run_len == BURST_CYC); // R3
  AST_EXIT_NOW: assert property (@(posedge clk) disable iff (rst) (seen && enter_tx) |=> !tx_elec_idle && !tx_detrx_lpbk && pattern_sel == 2'd1); // R4
  AST_TS2_NEEDS_OK: assert property (@(posedge clk) disable iff (rst) (seen && pattern_sel == 2'd3 && $past(pattern_sel) == 2'd2) |-> $past(rx_ts_ok)); // R6
  AST_U0_STICKY: assert property (@(posedge clk) disable iff (rst) u0_reached |=> u0_reached && pattern_sel == 2'd0); // R8
  AST_NO_DETECT_TX: assert property (@(posedge clk) disable iff (rst) seen |-> !(tx_detrx_lpbk && !tx_elec_idle)); // R9
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst) (seen && pattern_sel != $past(pattern_sel)) |-> pattern_sel == $past(pattern_sel) + 2'd1); // R10
  AST_EXIT_ONLY_LFPS: assert property (@(posedge clk) disable iff (rst) (seen && $fell(tx_elec_idle)) |-> $past(lfps_exit)); // R4

endmodule

bind pipe_poll_tx_ctrl pipe_poll_tx_ctrl_chk #(
  .BURST_CYC(BURST_CYC)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .lfps_exit    (lfps_exit),
  .rx_ts_ok     (rx_ts_ok),
  .power_down   (power_down),
  .tx_elec_idle (tx_elec_idle),
  .tx_detrx_lpbk(tx_detrx_lpbk),
  .pattern_sel  (pattern_sel),
  .u0_reached   (u0_reached),
  .enter_tx     (enter_tx)
);

// File: tb/pipe_poll_tx_ctrl_tb.sv
module pipe_poll_tx_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int BURST = 3;
  localparam int GAP   = 2;
  localparam int TSEQ  = 4;
  localparam int TS2N  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lfps_exit = 1'b0;
  logic       rx_ts_ok = 1'b0;
  logic       os_tick = 1'b0;
  logic [1:0] power_down;
  logic       tx_elec_idle;
  logic       tx_detrx_lpbk;
  logic [1:0] pattern_sel;
  logic       u0_reached;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = !clk;

  pipe_poll_tx_ctrl #(
    .BURST_CYC(BURST), .GAP_CYC(GAP), .TSEQ_SETS(TSEQ), .TS2_SETS(TS2N)
  ) dut_i (
    .clk(clk), .rst(rst), .lfps_exit(lfps_exit), .rx_ts_ok(rx_ts_ok),
    .os_tick(os_tick), .power_down(power_down), .tx_elec_idle(tx_elec_idle),
    .tx_detrx_lpbk(tx_detrx_lpbk), .pattern_sel(pattern_sel),
    .u0_reached(u0_reached)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cycles++;
  endtask

  // Expected outputs for a phase: pattern, idle, detect, u0.
  task automatic chk_phase(input string req, input int pat, input int idle, input int u0);
    chk(req, pattern_sel, pat);
    chk(req, tx_elec_idle, idle);
    chk(req, u0_reached, u0);
    chk({req, " R1"}, power_down, 0);
    if (!idle) chk({req, " R9"}, tx_detrx_lpbk, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    lfps_exit = 1'b0; rx_ts_ok = 1'b0; os_tick = 1'b0;
    step(); step();
    chk_phase("R2 reset", 0, 1, 0);
    chk("R2 reset detect", tx_detrx_lpbk, 0);
    rst = 1'b0;
  endtask

  initial begin
    #1;
    for (int exit_at = 0; exit_at < 12; exit_at++) begin
      do_reset();
      // R3: LFPS burst/gap positions counted from reset.
      for (int t = 0; t < exit_at; t++) begin
        chk("R3 lfps level", tx_detrx_lpbk, ((t % (GAP + BURST)) >= GAP) ? 1 : 0);
        chk("R3 idle", tx_elec_idle, 1);
        step();
      end
      chk("R3 lfps level", tx_detrx_lpbk, ((exit_at % (GAP + BURST)) >= GAP) ? 1 : 0);
      // R4: one-cycle exit pulse, immediate transmit mode.
      lfps_exit = 1'b1;
      step();
      lfps_exit = 1'b0;
      chk_phase("R4 enter TSEQ", 1, 0, 0);
      chk("R4 detect low", tx_detrx_lpbk, 0);
      // R5: TSEQ counts ticks, with irregular spacing.
      for (int k = 0; k < TSEQ; k++) begin
        if ((k + exit_at) % 2 == 1) begin
          step();
          chk_phase("R5 TSEQ no tick", 1, 0, 0);
        end
        os_tick = 1'b1;
        step();
        os_tick = 1'b0;
        chk_phase("R5 TSEQ count", (k == TSEQ - 1) ? 2 : 1, 0, 0);
      end
      // R9: stray ticks and exit pulses in TS1 are ignored.
      for (int k = 0; k <= exit_at % 3; k++) begin
        os_tick = 1'b1;
        lfps_exit = 1'b1;
        step();
        chk_phase("R9 TS1 holds", 2, 0, 0);
      end
      os_tick = 1'b0;
      lfps_exit = 1'b0;
      // R6: rx_ts_ok ends TS1.
      rx_ts_ok = 1'b1;
      step();
      rx_ts_ok = 1'b0;
      chk_phase("R6 enter TS2", 3, 0, 0);
      // R7: TS2 full count, then U0.
      for (int k = 0; k < TS2N; k++) begin
        os_tick = 1'b1;
        step();
        os_tick = 1'b0;
        if (k == TS2N - 1) chk_phase("R7 U0", 0, 0, 1);
        else chk_phase("R7 TS2 count R10", 3, 0, 0);
      end
      // R8: U0 sticky, inputs ignored.
      for (int k = 0; k < 3; k++) begin
        lfps_exit = 1'b1; rx_ts_ok = 1'b1; os_tick = 1'b1;
        step();
        chk_phase("R8 U0 sticky", 0, 0, 1);
      end
      lfps_exit = 1'b0; rx_ts_ok = 1'b0; os_tick = 1'b0;
    end
    // R3: long LFPS run without exit covers several periods.
    do_reset();
    for (int t = 0; t < 4 * (GAP + BURST); t++) begin
      chk("R3 long run", tx_detrx_lpbk, ((t % (GAP + BURST)) >= GAP) ? 1 : 0);
      step();
    end
    // R2: reset from mid-TSEQ returns to LFPS.
    lfps_exit = 1'b1; step(); lfps_exit = 1'b0;
    chk_phase("R4 enter TSEQ", 1, 0, 0);
    do_reset();
    chk("R3 after reset", tx_detrx_lpbk, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule